// File: doc/BRIEF.md
# Overlap-Aware Token Lane Splitter

A pattern matcher scanning one byte per cycle reports every token it finds, at every byte offset. Such reports can overlap. This block sorts them into a small set of lanes, so that each lane's FIFO holds a chain of tokens that do not overlap. Each report carries a pattern index, a pattern length in bytes and a timestamp taken from a free-running cycle counter.

Each lane remembers the cycle at which a token abutting its last one would arrive. That cycle is the last token's timestamp plus its length. A new token is compared with every active lane, and the result is one of three cases:
- The token arrives exactly on time, so it abuts that lane's last token.
- The token arrives late, so there is a gap before it.
- The token arrives early, so it overlaps that lane's last token and that lane cannot take it.

When no lane can take a token, the block either holds off the source or drops the token and marks the packet as suspicious. A parameter selects which. A synchronous packet-start strobe empties everything between packets.

Top module: `tok_lane_splitter`

## Requirements
- R1: After reset or a packet start, every lane is idle and its FIFO empty (`rdValid` all 0), `suspicious` is 0 and `tokReady` is 1.
- R2: A token written to a lane appears at that lane's FIFO head one clock edge after it is accepted. The lane's expected time becomes timestamp plus length. When all lanes are idle, the token goes to lane 0.
- R3: A token whose timestamp equals an active lane's expected time goes to that lane with gap flag 0. This takes priority over any lane where the token would leave a gap.
- R4: A token whose timestamp is earlier than a lane's expected time is never written to that lane. If no lane abuts it and no lane has a gap before it, it opens the lowest-numbered idle lane with gap flag 0.
- R5: If no active lane abuts a token and some active lane's expected time has passed, the token goes to such a lane with gap flag 1.
- R6: Among lanes of the same class (abut, gap or idle), the lowest-numbered lane is chosen.
- R7: Timestamps compare modulo 2^TS_W. A difference of timestamp minus expected time whose top bit is set means "earlier". With TS_W=16, a token at 0xFFFE with length 4 expects 0x0002 next, and a token at 0x0001 overlaps it.
- R8: With STALL_MODE=1, when no lane can accept a valid token, `tokReady` is 0 in that cycle and nothing is written.
- R9: With STALL_MODE=0, `tokReady` stays 1. A token that no lane can accept is dropped, and `suspicious` rises at the next edge and stays 1 until a packet start.
- R10: A lane whose FIFO is full (FIFO_DEPTH entries) cannot take a token. Each FIFO shows its oldest entry at its head, with `rdValid` high while it is non-empty, and a read pops it, so entries leave in write order.
- R11: A packet start clears every lane, every FIFO and `suspicious` at the next edge, and a token presented in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pktStart | input | 1 | Synchronous clear at packet start |
| tokValid | input | 1 | Token report valid |
| tokIdx | input | IDX_W | Pattern index |
| tokLen | input | LEN_W | Pattern length in bytes |
| tokTime | input | TS_W | Detection timestamp |
| tokReady | output | 1 | Token can be taken this cycle |
| suspicious | output | 1 | Sticky drop flag (flag mode only) |
| rdEn | input | NUM_LANES | Per-lane FIFO pop |
| rdValid | output | NUM_LANES | Per-lane FIFO non-empty |
| rdIdx | output | NUM_LANES*IDX_W | Per-lane head index, lane i at bits i*IDX_W upward |
| rdGap | output | NUM_LANES | Per-lane head gap flag |

## Verification
`tokReady` depends on the inputs only through combinational logic, so the bench reads it in the same cycle, after driving the token and before the edge. A written token appears at the FIFO head one edge after it is accepted. `suspicious` likewise changes one edge after the dropped token. The bench therefore reads both at the falling edge after the accepting rising edge. A pop and a packet start take effect at the following edge, and the bench checks their results at the falling edge after it.

// File: rtl/tls_pkg.sv
`timescale 1ns/1ps
package tls_pkg;
  localparam int MAX_LANES = 8;

  typedef struct packed {
    logic [MAX_LANES-1:0] wrSel;   // one-hot lane write strobe
    logic                 wrGap;   // gap flag stored with the token
    logic                 clrAll;  // packet-start clear
  } laneCtl_t;
endpackage

// File: rtl/tls_ctrl.sv
`timescale 1ns/1ps
module tls_ctrl
  import tls_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int TS_W       = 16,
  parameter int STALL_MODE = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pktStart,
  input  logic                 tokValid,
  input  logic [TS_W-1:0]      tokTime,
  input  logic [NUM_LANES-1:0] laneActive,
  input  logic [NUM_LANES-1:0] laneFull,
  input  logic [TS_W-1:0]      laneExp [NUM_LANES],
  output laneCtl_t             ctl,
  output logic                 tokReady,
  output logic                 suspicious
);
  logic [NUM_LANES-1:0] abutV, gapV, idleV, sel;
  logic                 selGap, found;

  // classify each lane against the incoming timestamp (modular compare)
  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) begin
      logic [TS_W-1:0] d;
      d        = tokTime - laneExp[i];
      abutV[i] = laneActive[i] && !laneFull[i] && (d == '0);
      gapV[i]  = laneActive[i] && !laneFull[i] && !d[TS_W-1] && (d != '0);
      idleV[i] = !laneActive[i];
    end
  end

  // priority: abut, then gap, then idle; lowest lane within each class
  always_comb begin
    sel    = '0;
    selGap = 1'b0;
    if (|abutV) begin
      sel = abutV & (~abutV + 1'b1);
    end else if (|gapV) begin
      sel    = gapV & (~gapV + 1'b1);
      selGap = 1'b1;
    end else if (|idleV) begin
      sel = idleV & (~idleV + 1'b1);
    end
    found = |sel;
  end

  always_comb begin
    ctl        = '0;
    ctl.clrAll = pktStart;
    ctl.wrGap  = selGap;
    if (tokValid && !pktStart)
      ctl.wrSel[NUM_LANES-1:0] = sel;
  end

  generate
    if (STALL_MODE != 0) begin : g_stall
      assign tokReady   = found;
      assign suspicious = 1'b0;
    end else begin : g_flag
      logic suspReg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               suspReg <= 1'b0;
        else if (pktStart)                        suspReg <= 1'b0;
        else if (tokValid && !found)              suspReg <= 1'b1;
      end
      assign tokReady   = 1'b1;
      assign suspicious = suspReg;
    end
  endgenerate
endmodule

// File: rtl/tls_datapath.sv
`timescale 1ns/1ps
module tls_datapath
  import tls_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int IDX_W      = 8,
  parameter int LEN_W      = 6,
  parameter int TS_W       = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  laneCtl_t                   ctl,
  input  logic [IDX_W-1:0]           tokIdx,
  input  logic [LEN_W-1:0]           tokLen,
  input  logic [TS_W-1:0]            tokTime,
  input  logic [NUM_LANES-1:0]       rdEn,
  output logic [NUM_LANES-1:0]       laneActive,
  output logic [NUM_LANES-1:0]       laneFull,
  output logic [TS_W-1:0]            laneExp [NUM_LANES],
  output logic [NUM_LANES-1:0]       rdValid,
  output logic [NUM_LANES*IDX_W-1:0] rdIdx,
  output logic [NUM_LANES-1:0]       rdGap
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int ENT_W = IDX_W + 1;

  logic [TS_W-1:0] nextExp;
  assign nextExp = tokTime + TS_W'(tokLen);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [ENT_W-1:0] mem [FIFO_DEPTH];
    logic [PTR_W-1:0] wrPtr, rdPtr;
    logic [CNT_W-1:0] count;
    logic             wr, rd;

    assign wr = ctl.wrSel[g];
    assign rd = rdEn[g] && (count != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        laneActive[g] <= 1'b0;
        laneExp[g]    <= '0;
        wrPtr         <= '0;
        rdPtr         <= '0;
        count         <= '0;
      end else if (ctl.clrAll) begin
        laneActive[g] <= 1'b0;
        laneExp[g]    <= '0;
        wrPtr         <= '0;
        rdPtr         <= '0;
        count         <= '0;
      end else begin
        if (wr) begin
          laneActive[g] <= 1'b1;
          laneExp[g]    <= nextExp;
          wrPtr         <= (FIFO_DEPTH > 1) ? PTR_W'(wrPtr + 1'b1) : '0;
        end
        if (rd)
          rdPtr <= (FIFO_DEPTH > 1) ? PTR_W'(rdPtr + 1'b1) : '0;
        if (wr && !rd)      count <= count + 1'b1;
        else if (rd && !wr) count <= count - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr && !ctl.clrAll)
        mem[wrPtr] <= {ctl.wrGap, tokIdx};
    end

    assign laneFull[g]                = (count == CNT_W'(FIFO_DEPTH));
    assign rdValid[g]                 = (count != '0);
    assign rdIdx[g*IDX_W +: IDX_W]    = mem[rdPtr][IDX_W-1:0];
    assign rdGap[g]                   = mem[rdPtr][IDX_W];
  end
endmodule

// File: rtl/tok_lane_splitter.sv
`timescale 1ns/1ps
module tok_lane_splitter
  import tls_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int IDX_W      = 8,
  parameter int LEN_W      = 6,
  parameter int TS_W       = 16,
  parameter int STALL_MODE = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pktStart,
  input  logic                       tokValid,
  input  logic [IDX_W-1:0]           tokIdx,
  input  logic [LEN_W-1:0]           tokLen,
  input  logic [TS_W-1:0]            tokTime,
  output logic                       tokReady,
  output logic                       suspicious,
  input  logic [NUM_LANES-1:0]       rdEn,
  output logic [NUM_LANES-1:0]       rdValid,
  output logic [NUM_LANES*IDX_W-1:0] rdIdx,
  output logic [NUM_LANES-1:0]       rdGap
);
  laneCtl_t             ctl;
  logic [NUM_LANES-1:0] laneActive, laneFull;
  logic [TS_W-1:0]      laneExp [NUM_LANES];

  tls_ctrl #(
    .NUM_LANES(NUM_LANES), .TS_W(TS_W), .STALL_MODE(STALL_MODE)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .pktStart(pktStart), .tokValid(tokValid),
    .tokTime(tokTime), .laneActive(laneActive), .laneFull(laneFull),
    .laneExp(laneExp), .ctl(ctl), .tokReady(tokReady), .suspicious(suspicious)
  );

  tls_datapath #(
    .NUM_LANES(NUM_LANES), .FIFO_DEPTH(FIFO_DEPTH), .IDX_W(IDX_W),
    .LEN_W(LEN_W), .TS_W(TS_W)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .tokIdx(tokIdx), .tokLen(tokLen),
    .tokTime(tokTime), .rdEn(rdEn), .laneActive(laneActive),
    .laneFull(laneFull), .laneExp(laneExp), .rdValid(rdValid),
    .rdIdx(rdIdx), .rdGap(rdGap)
  );
endmodule

// File: rtl/tls_checker.sv
`timescale 1ns/1ps
module tls_checker #(
  parameter int NUM_LANES = 4,
  parameter int IDX_W     = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       pktStart,
  input logic                       tokValid,
  input logic                       tokReady,
  input logic                       suspicious,
  input logic [NUM_LANES-1:0]       rdEn,
  input logic [NUM_LANES-1:0]       rdValid,
  input logic [NUM_LANES*IDX_W-1:0] rdIdx
);
  AST_ONE_LANE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    tokValid |=> ($countones(rdValid & ~$past(rdValid)) <= 1)); // R2

  AST_STALL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !tokReady |-> !suspicious); // R8

  AST_SUSP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    suspicious && !pktStart |=> suspicious); // R9

  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid[0] && !rdEn[0] && !pktStart |=> rdValid[0] && $stable(rdIdx[IDX_W-1:0])); // R10

  AST_PKT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pktStart |=> (rdValid == '0) && !suspicious); // R11
endmodule

bind tok_lane_splitter tls_checker #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rst_n(rst_n), .pktStart(pktStart), .tokValid(tokValid),
  .tokReady(tokReady), .suspicious(suspicious), .rdEn(rdEn),
  .rdValid(rdValid), .rdIdx(rdIdx)
);

// File: tb/sim_tok_lane_splitter.sv
`timescale 1ns/1ps
module sim_tok_lane_splitter;
  localparam int NL = 4;
  localparam int IW = 8;
  localparam int LW = 6;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pktStart = 1'b0;
  logic          tokValid = 1'b0;
  logic [IW-1:0] tokIdx = '0;
  logic [LW-1:0] tokLen = '0;
  logic [TW-1:0] tokTime = '0;
  logic [NL-1:0] rdEn = '0;

  logic          rdy0, susp0, rdy1, susp1;
  logic [NL-1:0] val0, gap0, val1, gap1;
  logic [NL*IW-1:0] idx0, idx1;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;
  logic lastRdy0, lastRdy1;

  always #2 clk = ~clk;

  tok_lane_splitter #(.STALL_MODE(1)) u0 (
    .clk(clk), .rst_n(rst_n), .pktStart(pktStart), .tokValid(tokValid),
    .tokIdx(tokIdx), .tokLen(tokLen), .tokTime(tokTime), .tokReady(rdy0),
    .suspicious(susp0), .rdEn(rdEn), .rdValid(val0), .rdIdx(idx0), .rdGap(gap0)
  );

  tok_lane_splitter #(.STALL_MODE(0)) u1 (
    .clk(clk), .rst_n(rst_n), .pktStart(pktStart), .tokValid(tokValid),
    .tokIdx(tokIdx), .tokLen(tokLen), .tokTime(tokTime), .tokReady(rdy1),
    .suspicious(susp1), .rdEn(rdEn), .rdValid(val1), .rdIdx(idx1), .rdGap(gap1)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic pulsePkt();
    @(negedge clk); pktStart = 1'b1;
    @(posedge clk); #1 pktStart = 1'b0;
  endtask

  task automatic sendTok(input int idx, input int len, input int t);
    @(negedge clk);
    tokValid = 1'b1; tokIdx = IW'(idx); tokLen = LW'(len); tokTime = TW'(t);
    #1 lastRdy0 = rdy0; lastRdy1 = rdy1;
    @(posedge clk); #1 tokValid = 1'b0;
  endtask

  task automatic popCheck(input int lane, input int expIdx, input bit expGap, input string tag);
    @(negedge clk);
    chk(val0[lane] === 1'b1, {tag, " head valid"}, int'(val0[lane]), 1);
    chk(idx0[lane*IW +: IW] === IW'(expIdx), {tag, " head index"}, int'(idx0[lane*IW +: IW]), expIdx);
    chk(gap0[lane] === expGap, {tag, " head gap"}, int'(gap0[lane]), int'(expGap));
    rdEn[lane] = 1'b1;
    @(posedge clk); #1 rdEn = '0;
  endtask

  task automatic emptyCheck(input int lane, input string tag);
    @(negedge clk);
    chk(val0[lane] === 1'b0, {tag, " lane empty"}, int'(val0[lane]), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(val0 === '0, "R1 fifos empty", int'(val0), 0);
    chk(rdy0 === 1'b1, "R1 ready", int'(rdy0), 1);
    chk(susp1 === 1'b0, "R1 no flag", int'(susp1), 0);
  endtask

  task automatic testAbutOverlap();
    pulsePkt();
    sendTok(1, 3, 10);                  // lane0, expects 13
    @(negedge clk);
    chk(val0 === 4'b0001, "R2 first token to lane0", int'(val0), 1);
    sendTok(2, 2, 13);                  // R3 abut lane0
    sendTok(3, 4, 12);                  // R4 overlaps lane0 (exp 15) -> lane1
    popCheck(0, 1, 1'b0, "R2 lane0 first");
    popCheck(0, 2, 1'b0, "R3 lane0 abut");
    emptyCheck(0, "R4 no overlap in lane0");
    popCheck(1, 3, 1'b0, "R4 overlap opens lane1");
  endtask

  task automatic testGapPriority();
    pulsePkt();
    sendTok(5, 2, 20);                  // lane0 exp 22
    sendTok(6, 3, 21);                  // overlap -> lane1 exp 24
    sendTok(7, 2, 24);                  // lane0 gap, lane1 abut -> lane1 (R3)
    sendTok(8, 1, 30);                  // both gap -> lane0 gap=1 (R5, R6)
    popCheck(0, 5, 1'b0, "R5 lane0 first");
    popCheck(0, 8, 1'b1, "R5 R6 gap token lowest lane");
    popCheck(1, 6, 1'b0, "R4 lane1 first");
    popCheck(1, 7, 1'b0, "R3 abut beats lower gap lane");
    emptyCheck(2, "R6 lane2 unused");
  endtask

  task automatic testWrap();
    pulsePkt();
    sendTok(10, 4, 16'hFFFE);           // lane0 exp 0x0002
    sendTok(11, 1, 16'h0001);           // earlier after wrap -> lane1 exp 2
    sendTok(12, 1, 16'h0002);           // abuts both -> lane0
    popCheck(0, 10, 1'b0, "R7 lane0 first");
    popCheck(0, 12, 1'b0, "R7 abut across wrap");
    popCheck(1, 11, 1'b0, "R7 wrapped overlap new lane");
    emptyCheck(1, "R7 lane1 single");
  endtask

  task automatic testNoLane();
    pulsePkt();
    for (int i = 0; i < NL; i++) sendTok(20 + i, 10, 100 + i);
    sendTok(24, 1, 104);                // overlaps all four lanes
    chk(lastRdy0 === 1'b0, "R8 stall ready low", int'(lastRdy0), 0);
    chk(lastRdy1 === 1'b1, "R9 flag mode ready high", int'(lastRdy1), 1);
    @(negedge clk);
    chk(susp1 === 1'b1, "R9 flag raised", int'(susp1), 1);
    chk(susp0 === 1'b0, "R8 stall mode no flag", int'(susp0), 0);
    @(negedge clk);
    chk(susp1 === 1'b1, "R9 flag sticky", int'(susp1), 1);
    for (int i = 0; i < NL; i++) begin
      popCheck(i, 20 + i, 1'b0, "R8 lane holds own token");
      emptyCheck(i, "R8 nothing written on stall");
    end
    pulsePkt();
    @(negedge clk);
    chk(susp1 === 1'b0, "R11 flag cleared", int'(susp1), 0);
  endtask

  task automatic testFull();
    pulsePkt();
    for (int i = 0; i < 4; i++) sendTok(30 + i, 1, i);
    sendTok(34, 1, 4);                  // abuts full lane0 -> lane1
    for (int i = 0; i < 4; i++) popCheck(0, 30 + i, 1'b0, "R10 fifo order");
    popCheck(1, 34, 1'b0, "R10 full lane skipped");
  endtask

  task automatic testPktClear();
    sendTok(40, 2, 50);
    @(negedge clk);
    pktStart = 1'b1; tokValid = 1'b1; tokIdx = 8'd41; tokLen = 6'd1; tokTime = 16'd52;
    @(posedge clk); #1 pktStart = 1'b0; tokValid = 1'b0;
    @(negedge clk);
    chk(val0 === '0, "R11 all lanes cleared, token ignored", int'(val0), 0);
    chk(rdy0 === 1'b1, "R1 ready after packet start", int'(rdy0), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    testReset();
    testAbutOverlap();
    testGapPriority();
    testWrap();
    testNoLane();
    testFull();
    testPktClear();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule